// File: doc/BRIEF.md
# Pipelined Register Bank Responder

This block is a small bank of general-purpose 32-bit registers that sits behind a simple CPU-side request/response protocol. A requester raises a one-cycle request strobe together with a write flag, a byte address and (for writes) write data. The block answers on two independent response channels: a read channel (acknowledge, error, data) and a write channel (acknowledge, error). Reads travel through a fixed-depth response pipeline, so each read is answered a parameterised number of cycles after it was issued. Writes are answered on the cycle after they are accepted.

Requests may be issued back to back without waiting for earlier answers. Reads are always accepted. A write is accepted only while the write-stall output is low. Write-stall therefore acts as the ready signal of the write path: it rises when a write is presented while earlier reads are still unanswered. While it is high, the requester keeps the strobe, write flag, address and data unchanged, and it drops once every earlier read has been answered. This back-pressure keeps all answers in the order the requests were issued. Any address other than the eight word-aligned register slots is answered normally but with the error flag set.

Top module: `regbank_responder`

## Requirements
- R1: A synchronous active-high reset clears every register to zero, empties the read pipeline and the count of unanswered reads, and holds `rd_ack` and `wr_ack` low while it is asserted.
- R2: A read presented in cycle t is answered with `rd_ack` high in cycle t+RD_LAT (default 2), with `rd_data` equal to the register contents in cycle t and `rd_err` low for a valid address.
- R3: Reads issued on consecutive cycles are answered on consecutive cycles, one per cycle, in issue order.
- R4: A write presented while `wr_stall` is low is accepted; `wr_ack` is high in the next cycle with `wr_err` low for a valid address, and a read issued after that ack returns the new value.
- R5: `wr_stall` is high exactly when a write is presented and at least one earlier read is still unanswered; a stalled write is held by the requester and is accepted in the first cycle in which `wr_stall` is low.
- R6: A write acknowledge never comes before the acknowledge of an earlier read, and `rd_ack` and `wr_ack` are never high in the same cycle.
- R7: The valid addresses are 0x00, 0x04, ..., 0x1C (address bits [1:0] zero and word index below 8); a read of any other address is answered on the normal schedule with the error flag high and data zero, and a write to it is acknowledged with `wr_err` high.
- R8: A write to an invalid address changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, one cycle per request (held while stalled) |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 8 | Byte address of the access |
| req_wdata | input | 32 | Write data, valid with a write request |
| wr_stall | output | 1 | Write not accepted this cycle; requester holds the request |
| rd_ack | output | 1 | Read answer strobe |
| rd_err | output | 1 | Read error, meaningful only with `rd_ack` |
| rd_data | output | 32 | Read data, meaningful only with `rd_ack` |
| wr_ack | output | 1 | Write answer strobe |
| wr_err | output | 1 | Write error, meaningful only with `wr_ack` |

## Verification
The bound checker watches, on every cycle, the stall rule against its own count of unanswered reads, the one-cycle write acknowledge, the exclusion of simultaneous read and write answers, quiet outputs after reset and zero data on failed reads. What the registers hold can only be shown by the bench's scenarios: read data against a model of the bank, the answer order of back-to-back reads, updates seen by later reads, and invalid-address writes that leave every register untouched. Reset in the middle of an unanswered read is also a bench scenario.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  // Kind of request presented in the current cycle.
  typedef enum logic [1:0] {
    REQ_IDLE  = 2'd0,
    REQ_READ  = 2'd1,
    REQ_WRITE = 2'd2
  } req_kind_e;

  // Control part of one read-pipeline stage.
  typedef struct packed {
    logic vld;
    logic err;
  } rsp_meta_t;

endpackage

// File: rtl/regbank_addr_decode.sv
module regbank_addr_decode #(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              in_range;

  assign word     = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign in_range = (32'(word) < NUM_REGS);
  assign hit      = aligned && in_range;
  assign idx      = word[IDX_W-1:0];

endmodule

// File: rtl/regbank_storage.sv
module regbank_storage #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        regs[g] <= wr_data;
      end
    end
  end

  // Mux written as a loop so an out-of-range index reads zero.
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_en && (rd_idx == IDX_W'(i))) begin
        rd_data = regs[i];
      end
    end
  end

endmodule

// File: rtl/regbank_read_pipe.sv
module regbank_read_pipe
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic              in_err,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_vld,
  output logic              out_err,
  output logic [DATA_W-1:0] out_data
);

  rsp_meta_t         meta [LAT];
  logic [DATA_W-1:0] data [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          meta[0] <= '0;
          data[0] <= '0;
        end else begin
          meta[0].vld <= in_vld;
          meta[0].err <= in_vld && in_err;
          data[0]     <= (in_vld && !in_err) ? in_data : '0;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) begin
          meta[g] <= '0;
          data[g] <= '0;
        end else begin
          meta[g] <= meta[g-1];
          data[g] <= data[g-1];
        end
      end
    end
  end

  assign out_vld  = meta[LAT-1].vld;
  assign out_err  = meta[LAT-1].err;
  assign out_data = data[LAT-1];

endmodule

// File: rtl/regbank_order_ctl.sv
module regbank_order_ctl #(
  parameter int MAX_OUT = 3,
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_accept,
  input  logic rd_retire,
  input  logic wr_req,
  output logic wr_stall
);

  logic [CNT_W-1:0] pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
    end else begin
      case ({rd_accept, rd_retire})
        2'b10:   pending <= pending + 1'b1;
        2'b01:   pending <= pending - 1'b1;
        default: pending <= pending;
      endcase
    end
  end

  assign wr_stall = wr_req && (pending != '0);

endmodule

// File: rtl/regbank_responder.sv
module regbank_responder
  import regbank_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 8,
  parameter int RD_LAT   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              wr_stall,
  output logic              rd_ack,
  output logic              rd_err,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_ack,
  output logic              wr_err
);

  localparam int IDX_W = $clog2(NUM_REGS);

  req_kind_e         kind;
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic              wr_fire;
  logic              rd_fire;
  logic [DATA_W-1:0] lookup;

  always_comb begin
    if (!req_valid)     kind = REQ_IDLE;
    else if (req_write) kind = REQ_WRITE;
    else                kind = REQ_READ;
  end

  regbank_addr_decode #(
    .ADDR_W  (ADDR_W),
    .NUM_REGS(NUM_REGS)
  ) u_decode (
    .addr(req_addr),
    .hit (hit),
    .idx (idx)
  );

  regbank_order_ctl #(
    .MAX_OUT(RD_LAT + 1)
  ) u_order (
    .clk      (clk),
    .rst      (rst),
    .rd_accept(rd_fire),
    .rd_retire(rd_ack),
    .wr_req   (kind == REQ_WRITE),
    .wr_stall (wr_stall)
  );

  assign rd_fire = (kind == REQ_READ);
  assign wr_fire = (kind == REQ_WRITE) && !wr_stall;

  regbank_storage #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS)
  ) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_fire && hit),
    .wr_idx (idx),
    .wr_data(req_wdata),
    .rd_en  (rd_fire && hit),
    .rd_idx (idx),
    .rd_data(lookup)
  );

  regbank_read_pipe #(
    .DATA_W(DATA_W),
    .LAT   (RD_LAT)
  ) u_rpipe (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (rd_fire),
    .in_err  (!hit),
    .in_data (lookup),
    .out_vld (rd_ack),
    .out_err (rd_err),
    .out_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ack <= 1'b0;
      wr_err <= 1'b0;
    end else begin
      wr_ack <= wr_fire;
      wr_err <= wr_fire && !hit;
    end
  end

endmodule

// File: rtl/regbank_checker.sv
module regbank_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              wr_stall,
  input logic              rd_ack,
  input logic              rd_err,
  input logic [DATA_W-1:0] rd_data,
  input logic              wr_ack,
  input logic              wr_err
);

  // Independent count of reads seen at the ports and not yet answered.
  logic [7:0] open_rd;
  logic       rd_seen;

  assign rd_seen = req_valid && !req_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_rd <= '0;
    end else begin
      open_rd <= open_rd + {7'd0, rd_seen} - {7'd0, rd_ack};
    end
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (!rd_ack && !wr_ack));

  assert_rd_ack_has_read_R3: assert property (@(posedge clk) disable iff (rst)
    rd_ack |-> (open_rd != 8'd0));

  assert_wr_ack_next_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !wr_stall) |=> wr_ack);

  assert_stall_needs_write_R5: assert property (@(posedge clk) disable iff (rst)
    wr_stall |-> (req_valid && req_write));

  assert_stall_behind_reads_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && (open_rd != 8'd0)) |-> wr_stall);

  assert_no_stall_when_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (open_rd == 8'd0) |-> !wr_stall);

  assert_stalled_req_held_R5: assert property (@(posedge clk) disable iff (rst)
    wr_stall |=> (req_valid && req_write && $stable(req_addr) && $stable(req_wdata)));

  assert_split_acks_R6: assert property (@(posedge clk) disable iff (rst)
    !(rd_ack && wr_ack));

  assert_failed_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && rd_err) |-> (rd_data == '0));

  logic unused_ok;
  assign unused_ok = wr_err;

endmodule

bind regbank_responder regbank_checker #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_checker (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_wdata(req_wdata),
  .wr_stall (wr_stall),
  .rd_ack   (rd_ack),
  .rd_err   (rd_err),
  .rd_data  (rd_data),
  .wr_ack   (wr_ack),
  .wr_err   (wr_err)
);

// File: tb/tb_regbank_responder.sv
`timescale 1ns/1ps
module tb_regbank_responder;

  localparam int RD_LAT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        wr_stall, rd_ack, rd_err, wr_ack, wr_err;
  logic [31:0] rd_data;

  always #5 clk = ~clk;

  regbank_responder #(.RD_LAT(RD_LAT)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .wr_stall(wr_stall),
    .rd_ack(rd_ack), .rd_err(rd_err), .rd_data(rd_data),
    .wr_ack(wr_ack), .wr_err(wr_err)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string tag = "R2";

  int          q_due[$];
  logic [31:0] q_data[$];
  logic        q_err[$];
  bit          w_pend = 0;
  int          w_due = 0;
  logic        w_err_exp = 0;
  logic [31:0] model [8];

  function automatic bit bad_addr(input logic [7:0] a);
    return (a[1:0] != 2'b00) || (a[7:2] >= 6'd8);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // One clock: check the outputs of this cycle, then drive the next request.
  task automatic step(input bit v, input bit w, input logic [7:0] a,
                      input logic [31:0] d, output bit acc);
    int  pend;
    bit  exp_rd, exp_wr, exp_stall;
    @(negedge clk);
    cyc++;
    pend   = q_due.size();
    exp_rd = (pend > 0) && (q_due[0] == cyc);
    chk(rd_ack === exp_rd, "R3", "rd_ack", 32'(rd_ack), 32'(exp_rd));
    if (exp_rd) begin
      chk(rd_err === q_err[0], q_err[0] ? "R7" : tag, "rd_err", 32'(rd_err), 32'(q_err[0]));
      chk(rd_data === q_data[0], q_err[0] ? "R7" : tag, "rd_data", rd_data, q_data[0]);
      void'(q_due.pop_front());
      void'(q_data.pop_front());
      void'(q_err.pop_front());
    end
    exp_wr = w_pend && (w_due == cyc);
    chk(wr_ack === exp_wr, "R4", "wr_ack", 32'(wr_ack), 32'(exp_wr));
    if (exp_wr) begin
      chk(wr_err === w_err_exp, w_err_exp ? "R7" : "R4", "wr_err", 32'(wr_err), 32'(w_err_exp));
      w_pend = 0;
    end
    chk(!(rd_ack && wr_ack), "R6", "rd_ack&wr_ack", 32'(rd_ack && wr_ack), 32'd0);
    req_valid = v;
    req_write = w;
    req_addr  = a;
    req_wdata = d;
    #1;
    exp_stall = v && w && (pend > 0);
    chk(wr_stall === exp_stall, "R5", "wr_stall", 32'(wr_stall), 32'(exp_stall));
    acc = v && !(w && exp_stall);
    if (acc) begin
      if (w) begin
        w_pend    = 1;
        w_due     = cyc + 1;
        w_err_exp = bad_addr(a);
        if (!bad_addr(a)) model[a[4:2]] = d;
      end else begin
        q_due.push_back(cyc + RD_LAT);
        q_err.push_back(bad_addr(a));
        q_data.push_back(bad_addr(a) ? 32'd0 : model[a[4:2]]);
      end
    end
  endtask

  // Present a request and hold it until accepted.
  task automatic do_req(input bit v, input bit w, input logic [7:0] a, input logic [31:0] d);
    bit acc;
    do step(v, w, a, d, acc); while (v && !acc);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) do_req(0, 0, 8'd0, 32'd0);
  endtask

  initial begin : watchdog
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 8; i++) model[i] = 32'd0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!rd_ack && !wr_ack, "R1", "acks in reset", {30'd0, rd_ack, wr_ack}, 32'd0);
    rst = 1'b0;

    // R1: all registers read zero after reset
    tag = "R1";
    for (int i = 0; i < 8; i++) do_req(1, 0, 8'(i * 4), 32'd0);
    idle(RD_LAT + 1);

    // R4: write then immediate read of the same register
    tag = "R4";
    do_req(1, 1, 8'h08, 32'hCAFE_0001);
    do_req(1, 0, 8'h08, 32'd0);
    do_req(1, 1, 8'h1C, 32'h1234_5678);
    idle(1);
    do_req(1, 0, 8'h1C, 32'd0);
    idle(RD_LAT + 1);

    // R3: back-to-back reads after filling every register
    for (int i = 0; i < 8; i++) do_req(1, 1, 8'(i * 4), 32'hA5A5_0000 + 32'(i));
    tag = "R3";
    for (int i = 7; i >= 0; i--) do_req(1, 0, 8'(i * 4), 32'd0);

    // R5/R6: write right behind reads stalls until they are answered
    tag = "R6";
    do_req(1, 0, 8'h00, 32'd0);
    do_req(1, 0, 8'h04, 32'd0);
    do_req(1, 1, 8'h00, 32'hDEAD_BEEF);
    do_req(1, 0, 8'h00, 32'd0);
    idle(RD_LAT + 1);

    // R7: misaligned and out-of-range accesses
    do_req(1, 0, 8'h05, 32'd0);
    do_req(1, 0, 8'h20, 32'd0);
    do_req(1, 0, 8'hFC, 32'd0);
    idle(RD_LAT + 1);

    // R8: invalid-address writes leave every register unchanged
    do_req(1, 1, 8'h20, 32'hFFFF_FFFF);
    do_req(1, 1, 8'h06, 32'hFFFF_FFFF);
    do_req(1, 1, 8'h43, 32'hFFFF_FFFF);
    tag = "R8";
    for (int i = 0; i < 8; i++) do_req(1, 0, 8'(i * 4), 32'd0);
    idle(RD_LAT + 1);

    // R1: reset with a read in flight drops it and clears the count
    do_req(1, 0, 8'h04, 32'd0);
    @(negedge clk);
    cyc++;
    rst = 1'b1;
    req_valid = 1'b0;
    q_due.delete(); q_data.delete(); q_err.delete(); w_pend = 0;
    for (int i = 0; i < 8; i++) model[i] = 32'd0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      cyc++;
      chk(!rd_ack && !wr_ack, "R1", "acks during reset", {30'd0, rd_ack, wr_ack}, 32'd0);
    end
    rst = 1'b0;
    tag = "R1";
    do_req(1, 1, 8'h10, 32'h0000_0042);
    do_req(1, 0, 8'h04, 32'd0);
    do_req(1, 0, 8'h10, 32'd0);
    idle(RD_LAT + 1);

    // Random mix of reads, writes and idles
    tag = "R2";
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      logic [7:0]  a;
      r = $urandom % 10;
      a = ($urandom % 12 == 0) ? 8'($urandom) : 8'(($urandom % 8) * 4);
      if (r < 2)      do_req(0, 0, 8'd0, 32'd0);
      else if (r < 6) do_req(1, 0, a, 32'd0);
      else            do_req(1, 1, a, $urandom);
    end
    idle(RD_LAT + 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule